// File: doc/BRIEF.md
# Far-Wordline Replica Write Checker

This block sits beside a multi-ported register array whose rows are split into equal halves. In each half the row with the longest wordline, the last row of the half, is the one most likely to suffer a late, failed write when the wordline settles too slowly. The checker keeps one replica word per half, stored close to the control logic where write timing is not in doubt. Every write that targets a far row also loads the replica of that half.

When the far row is later read, the word returned by the main array is compared with the replica. The array word is always passed through to the output. A one-bit flag is raised alongside it when the two words differ. Reads of any other row pass through with the flag low. A result state machine has three states. `RES_IDLE` means no read completed in the last cycle. `RES_PASS` means a read completed with no mismatch. `RES_FAIL` means a read of a far row disagreed with its replica. From any state the machine moves to `RES_IDLE` on a cycle without a read, to `RES_FAIL` on a read that mismatches, and to `RES_PASS` on any other read.

Writes land before reads within a cycle. So when a read and a write hit the same far row in one cycle, the array is expected to return the new word, and the comparison uses that incoming word instead of the stale replica.

Top module: `far_wl_checker`

## Requirements
- R1: Asynchronous active-low reset clears both replicas to zero, clears `rd_data` to zero and puts the result state in `RES_IDLE`, so `rd_valid` and `rd_err` are 0.
- R2: With 64 rows in two halves, rows 0 to 31 form half 0 and rows 32 to 63 form half 1. The far rows are 31 and 63, the rows whose five low address bits are all ones; the top address bit selects the half.
- R3: A write with `wr_en` high to a far row stores `wr_data` into that half's replica only; the other half's replica is unchanged.
- R4: A read (`rd_en` high) of a far row sets `rd_err` to 1 in the next cycle if `arr_rd_data` differs from that half's replica in any bit, and to 0 if all 74 bits match.
- R5: A read of any row that is not a far row gives `rd_err` = 0 in the next cycle, whatever the array returns.
- R6: On every read, `rd_data` in the next cycle equals the `arr_rd_data` sampled with the read, mismatch or not, and `rd_valid` is 1 in that cycle.
- R7: When a write and a read target the same far row in one cycle, the comparison is made against the incoming `wr_data`, and that word also becomes the replica.
- R8: A cycle with `rd_en` low gives `rd_valid` = 0 and `rd_err` = 0 in the next cycle, and `rd_data` keeps its previous value.
- R9: A write to a row that is not a far row leaves both replicas unchanged.
- R10: With `wr_en` low, `wr_addr` and `wr_data` have no effect on the replicas.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe into the array this cycle |
| wr_addr | input | 6 | Row being written |
| wr_data | input | 74 | Word being written |
| rd_en | input | 1 | Read strobe this cycle |
| rd_addr | input | 6 | Row being read |
| arr_rd_data | input | 74 | Word the main array returns for `rd_addr` in the same cycle |
| rd_data | output | 74 | Registered read word |
| rd_valid | output | 1 | `rd_data` and `rd_err` hold a read result |
| rd_err | output | 1 | Far-row mismatch flag for that read |

## Verification
A replica that is stale, loaded into the wrong half, or loaded by a non-far or disabled write stays hidden until the next read of a far row. It then shows up as a wrong `rd_err` exactly one cycle after that read. For this reason the bench follows every replica-altering stimulus with reads of both far rows, using array contents chosen so that each wrong replica value flips the flag. A wrong result state shows up on `rd_valid` or `rd_err` in the cycle after the read or idle cycle that caused it. The same-cycle forwarding path is exercised with both matching and corrupted array words.

// File: rtl/far_wl_pkg.sv
package far_wl_pkg;

    // Default geometry of the protected array
    localparam int unsigned DEF_ROWS   = 64;
    localparam int unsigned DEF_WIDTH  = 74;
    localparam int unsigned DEF_HALVES = 2;

    // Result of the most recent cycle as seen at the outputs
    typedef enum logic [1:0] {
        RES_IDLE = 2'd0,
        RES_PASS = 2'd1,
        RES_FAIL = 2'd2
    } res_state_e;

endpackage

// File: rtl/far_wl_row_decode.sv
module far_wl_row_decode #(
    parameter int unsigned ROWS   = far_wl_pkg::DEF_ROWS,
    parameter int unsigned HALVES = far_wl_pkg::DEF_HALVES,
    localparam int unsigned ADDR_W = $clog2(ROWS),
    localparam int unsigned ROW_W  = $clog2(ROWS / HALVES),
    localparam int unsigned HIDX_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              far_row,
    output logic [HIDX_W-1:0] half_idx
);

    // The far wordline of a half is its last row: all in-half bits set
    assign far_row = &addr[ROW_W-1:0];

    generate
        if (HALVES > 1) begin : g_split
            assign half_idx = addr[ADDR_W-1:ROW_W];
        end else begin : g_single
            assign half_idx = '0;
        end
    endgenerate

endmodule

// File: rtl/far_wl_replica_bank.sv
module far_wl_replica_bank #(
    parameter int unsigned WIDTH  = far_wl_pkg::DEF_WIDTH,
    parameter int unsigned HALVES = far_wl_pkg::DEF_HALVES,
    localparam int unsigned HIDX_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load,
    input  logic [HIDX_W-1:0]             load_half,
    input  logic [WIDTH-1:0]              load_word,
    output logic [HALVES-1:0][WIDTH-1:0]  words
);

    generate
        for (genvar h = 0; h < HALVES; h++) begin : g_half
            logic sel;
            assign sel = load && (load_half == HIDX_W'(h));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    words[h] <= '0;
                end else if (sel) begin
                    words[h] <= load_word;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/far_wl_compare.sv
module far_wl_compare #(
    parameter int unsigned WIDTH  = far_wl_pkg::DEF_WIDTH,
    parameter int unsigned HALVES = far_wl_pkg::DEF_HALVES,
    localparam int unsigned HIDX_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic                          rd_far,
    input  logic [HIDX_W-1:0]             rd_half,
    input  logic [HALVES-1:0][WIDTH-1:0]  replicas,
    input  logic                          fwd_en,
    input  logic [WIDTH-1:0]              fwd_word,
    input  logic [WIDTH-1:0]              arr_word,
    output logic                          mismatch
);

    logic [WIDTH-1:0] ref_word;

    // A same-cycle write to the read row lands first, so it is the reference
    always_comb begin
        ref_word = replicas[rd_half];
        if (fwd_en) begin
            ref_word = fwd_word;
        end
    end

    assign mismatch = rd_far && (|(arr_word ^ ref_word));

endmodule

// File: rtl/far_wl_checker.sv
module far_wl_checker #(
    parameter int unsigned ROWS   = far_wl_pkg::DEF_ROWS,
    parameter int unsigned WIDTH  = far_wl_pkg::DEF_WIDTH,
    parameter int unsigned HALVES = far_wl_pkg::DEF_HALVES,
    localparam int unsigned ADDR_W = $clog2(ROWS),
    localparam int unsigned HIDX_W = (HALVES > 1) ? $clog2(HALVES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WIDTH-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [WIDTH-1:0]  arr_rd_data,
    output logic [WIDTH-1:0]  rd_data,
    output logic              rd_valid,
    output logic              rd_err
);

    import far_wl_pkg::*;

    logic                         wr_far;
    logic [HIDX_W-1:0]            wr_half;
    logic                         rd_far;
    logic [HIDX_W-1:0]            rd_half;
    logic [HALVES-1:0][WIDTH-1:0] replica_q;
    logic                         replica_load;
    logic                         same_row_fwd;
    logic                         far_mismatch;
    res_state_e                   state_q;
    res_state_e                   state_d;

    far_wl_row_decode #(.ROWS(ROWS), .HALVES(HALVES)) u_wr_dec (
        .addr     (wr_addr),
        .far_row  (wr_far),
        .half_idx (wr_half)
    );

    far_wl_row_decode #(.ROWS(ROWS), .HALVES(HALVES)) u_rd_dec (
        .addr     (rd_addr),
        .far_row  (rd_far),
        .half_idx (rd_half)
    );

    assign replica_load = wr_en && wr_far;

    far_wl_replica_bank #(.WIDTH(WIDTH), .HALVES(HALVES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (replica_load),
        .load_half (wr_half),
        .load_word (wr_data),
        .words     (replica_q)
    );

    assign same_row_fwd = replica_load && (wr_addr == rd_addr);

    far_wl_compare #(.WIDTH(WIDTH), .HALVES(HALVES)) u_cmp (
        .rd_far   (rd_far),
        .rd_half  (rd_half),
        .replicas (replica_q),
        .fwd_en   (same_row_fwd),
        .fwd_word (wr_data),
        .arr_word (arr_rd_data),
        .mismatch (far_mismatch)
    );

    // Next-state selection
    always_comb begin
        state_d = RES_IDLE;
        unique case (state_q)
            RES_IDLE, RES_PASS, RES_FAIL: begin
                if (!rd_en) begin
                    state_d = RES_IDLE;
                end else if (far_mismatch) begin
                    state_d = RES_FAIL;
                end else begin
                    state_d = RES_PASS;
                end
            end
            default: state_d = RES_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        rd_valid = 1'b0;
        rd_err   = 1'b0;
        unique case (state_q)
            RES_IDLE: begin
                rd_valid = 1'b0;
                rd_err   = 1'b0;
            end
            RES_PASS: begin
                rd_valid = 1'b1;
                rd_err   = 1'b0;
            end
            RES_FAIL: begin
                rd_valid = 1'b1;
                rd_err   = 1'b1;
            end
            default: begin
                rd_valid = 1'b0;
                rd_err   = 1'b0;
            end
        endcase
    end

    // Read word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= arr_rd_data;
        end
    end

endmodule

// File: rtl/far_wl_checker_sva.sv
module far_wl_checker_sva #(
    parameter int unsigned ROWS   = far_wl_pkg::DEF_ROWS,
    parameter int unsigned WIDTH  = far_wl_pkg::DEF_WIDTH,
    parameter int unsigned HALVES = far_wl_pkg::DEF_HALVES,
    localparam int unsigned ADDR_W = $clog2(ROWS),
    localparam int unsigned ROW_W  = $clog2(ROWS / HALVES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WIDTH-1:0]  wr_data,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [WIDTH-1:0]  arr_rd_data,
    input logic [WIDTH-1:0]  rd_data,
    input logic              rd_valid,
    input logic              rd_err
);

    logic rd_is_far;
    logic same_far;

    assign rd_is_far = &rd_addr[ROW_W-1:0];
    assign same_far  = wr_en && rd_en && rd_is_far && (wr_addr == rd_addr);

    // R1: held in reset, the outputs read idle one cycle later
    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && !rd_err));

    // R4: a flag only ever accompanies a read result
    p_err_has_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_err |-> rd_valid);

    // R5: ordinary rows never raise the flag
    p_plain_row_clean_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_is_far) |=> !rd_err);

    // R6: read word appears one cycle later with the valid
    p_read_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rd_valid && rd_data == $past(arr_rd_data)));

    // R7: same-cycle write and read of a far row compare against the new word
    p_fwd_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (same_far && arr_rd_data == wr_data) |=> !rd_err);

    p_fwd_mismatch_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (same_far && arr_rd_data != wr_data) |=> rd_err);

    // R8: an idle cycle clears the result and keeps the word
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (!rd_valid && !rd_err && $stable(rd_data)));

endmodule

bind far_wl_checker far_wl_checker_sva #(
    .ROWS   (ROWS),
    .WIDTH  (WIDTH),
    .HALVES (HALVES)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_addr     (rd_addr),
    .arr_rd_data (arr_rd_data),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .rd_err      (rd_err)
);

// File: tb/far_wl_checker_bench.sv
`timescale 1ns/1ps
module far_wl_checker_bench;

    localparam int W = 74;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dut_we = 1'b0;
    logic          arr_we = 1'b0;
    logic [5:0]    wr_addr = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  fault_mask = '0;
    logic          rd_en = 1'b0;
    logic [5:0]    rd_addr = '0;
    logic [W-1:0]  arr_rd_data;
    logic [W-1:0]  rd_data;
    logic          rd_valid;
    logic          rd_err;

    logic [W-1:0]  arr_mem [64];
    int            checks = 0;
    int            errors = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    far_wl_checker u_far_wl_checker (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (dut_we),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_addr     (rd_addr),
        .arr_rd_data (arr_rd_data),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .rd_err      (rd_err)
    );

    // Main array model; fault_mask is the fault injection hook
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) arr_mem[i] <= '0;
        end else if (arr_we) begin
            arr_mem[wr_addr] <= wr_data ^ fault_mask;
        end
    end

    assign arr_rd_data = (arr_we && wr_addr == rd_addr) ? (wr_data ^ fault_mask)
                                                        : arr_mem[rd_addr];

    task automatic chk(input string req, input logic ev, input logic ee,
                       input logic [W-1:0] ed);
        checks++;
        if (rd_valid !== ev || rd_err !== ee || rd_data !== ed) begin
            errors++;
            $display("FAIL %s: valid=%b err=%b data=%h expected valid=%b err=%b data=%h",
                     req, rd_valid, rd_err, rd_data, ev, ee, ed);
        end
    endtask

    // One cycle of stimulus: driven at negedge, result sampled at the next negedge
    task automatic cyc(input logic awe, input logic dwe, input logic [5:0] wa,
                       input logic [W-1:0] wd, input logic [W-1:0] fm,
                       input logic re, input logic [5:0] ra);
        arr_we = awe; dut_we = dwe; wr_addr = wa; wr_data = wd;
        fault_mask = fm; rd_en = re; rd_addr = ra;
        @(posedge clk);
        @(negedge clk);
        arr_we = 1'b0; dut_we = 1'b0; rd_en = 1'b0; fault_mask = '0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [W-1:0] d, input logic [W-1:0] fm);
        cyc(1'b1, 1'b1, a, d, fm, 1'b0, 6'd0);
    endtask

    task automatic rd(input logic [5:0] a);
        cyc(1'b0, 1'b0, 6'd0, '0, '0, 1'b1, a);
    endtask

    localparam logic [W-1:0] VA  = {10'h2a5, 64'h0123_4567_89ab_cdef};
    localparam logic [W-1:0] VB  = {10'h15a, 64'hfedc_ba98_7654_3210};
    localparam logic [W-1:0] VC  = {10'h3ff, 64'h5555_aaaa_5555_aaaa};
    localparam logic [W-1:0] VD  = {10'h001, 64'h8000_0000_0000_0001};
    localparam logic [W-1:0] VE  = {10'h0f0, 64'h0f0f_0f0f_0f0f_0f0f};
    localparam logic [W-1:0] MHI = {1'b1, 73'd0};
    localparam logic [W-1:0] MLO = {73'd0, 1'b1};

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", 1'b0, 1'b0, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", 1'b0, 1'b0, '0);
        rd(6'd31);
        chk("R1 replica 0 cleared", 1'b1, 1'b0, '0);
        // array only, replica untouched: cleared replica must disagree
        cyc(1'b1, 1'b0, 6'd63, VE, '0, 1'b0, 6'd0);
        rd(6'd63);
        chk("R1 replica 1 cleared, R4 mismatch", 1'b1, 1'b1, VE);
    endtask

    task automatic t_clean_writes;
        wr(6'd31, VA, '0);
        rd(6'd31);
        chk("R3 R6 far row 31 clean", 1'b1, 1'b0, VA);
        wr(6'd63, VB, '0);
        rd(6'd63);
        chk("R3 far row 63 clean", 1'b1, 1'b0, VB);
        rd(6'd31);
        chk("R3 R2 half 0 replica kept", 1'b1, 1'b0, VA);
    endtask

    task automatic t_far_fault;
        wr(6'd63, VC, MHI);
        rd(6'd63);
        chk("R4 R6 far row 63 bad write", 1'b1, 1'b1, VC ^ MHI);
        rd(6'd31);
        chk("R2 R4 half 0 unaffected", 1'b1, 1'b0, VA);
        wr(6'd31, VB, MLO);
        rd(6'd31);
        chk("R4 far row 31 low bit fault", 1'b1, 1'b1, VB ^ MLO);
        wr(6'd63, VB, '0);
        rd(6'd63);
        chk("R4 clean rewrite clears", 1'b1, 1'b0, VB);
        wr(6'd31, VA, '0);
    endtask

    task automatic t_plain_rows;
        wr(6'd5, VC, MHI);
        rd(6'd5);
        chk("R5 row 5 fault unflagged", 1'b1, 1'b0, VC ^ MHI);
        wr(6'd32, VD, MLO);
        rd(6'd32);
        chk("R5 R2 row 32 fault unflagged", 1'b1, 1'b0, VD ^ MLO);
        wr(6'd62, VE, MLO);
        rd(6'd62);
        chk("R5 row 62 fault unflagged", 1'b1, 1'b0, VE ^ MLO);
    endtask

    task automatic t_plain_no_replica;
        wr(6'd30, VC, '0);
        rd(6'd31);
        chk("R9 row 30 write keeps replica 0", 1'b1, 1'b0, VA);
        wr(6'd47, VD, '0);
        rd(6'd63);
        chk("R9 row 47 write keeps replica 1", 1'b1, 1'b0, VB);
    endtask

    task automatic t_same_cycle;
        cyc(1'b1, 1'b1, 6'd31, VD, '0, 1'b1, 6'd31);
        chk("R7 same cycle clean", 1'b1, 1'b0, VD);
        cyc(1'b1, 1'b1, 6'd63, VE, MHI, 1'b1, 6'd63);
        chk("R7 same cycle fault", 1'b1, 1'b1, VE ^ MHI);
        rd(6'd63);
        chk("R7 replica took new word", 1'b1, 1'b1, VE ^ MHI);
        rd(6'd31);
        chk("R7 replica 0 took new word", 1'b1, 1'b0, VD);
    endtask

    task automatic t_idle;
        rd(6'd63);
        chk("R8 setup failing read", 1'b1, 1'b1, VE ^ MHI);
        cyc(1'b0, 1'b0, 6'd0, '0, '0, 1'b0, 6'd63);
        chk("R8 idle after fail", 1'b0, 1'b0, VE ^ MHI);
        cyc(1'b0, 1'b0, 6'd0, '0, '0, 1'b0, 6'd31);
        chk("R8 idle holds word", 1'b0, 1'b0, VE ^ MHI);
    endtask

    task automatic t_write_disabled;
        cyc(1'b0, 1'b0, 6'd31, VC, '0, 1'b0, 6'd0);
        rd(6'd31);
        chk("R10 disabled write ignored row 31", 1'b1, 1'b0, VD);
        wr(6'd63, VA, '0);
        cyc(1'b0, 1'b0, 6'd63, VB, '0, 1'b0, 6'd0);
        rd(6'd63);
        chk("R10 disabled write ignored row 63", 1'b1, 1'b0, VA);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_clean_writes();
        t_far_fault();
        t_plain_rows();
        t_plain_no_replica();
        t_same_cycle();
        t_idle();
        t_write_disabled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule